// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block turns one block load/store request into a series of single-word memory transfers. A request carries a 16-bit register list, a base address, a direction bit and a base-update bit, and a one-cycle start strobe launches it. The sequencer walks the selected registers from the lowest index to the highest. Each register gets the next word address, starting at the base itself, which is the increment-after addressing mode.

Each transfer is offered with a valid strobe, a register index, a word address and the direction. The transfer completes in any cycle where the ready input is high, so a slow memory or register port can stall the walk. After the last transfer the block gives a one-cycle done pulse. With that pulse it presents the updated base (base plus four bytes per selected register) and a writeback strobe when base update was requested. The register file and the memory sit outside the block.

Top module: `blk_xfer_seq`

## Requirements
- R1: While reset is asserted, and in the cycle after it, xfer_valid_o, done_o, wb_o and busy_o are all low. A reset in the middle of a sequence abandons it.
- R2: A start accepted while idle with a non-empty list puts xfer_valid_o high in the next cycle. At that point xfer_addr_o equals the captured base and xfer_idx_o is the lowest set bit of the list.
- R3: Each transfer taken with ready high moves to the next higher set bit of the list, and the address rises by 4. Exactly one transfer is offered per selected register.
- R4: While ready is low, xfer_valid_o stays high and xfer_idx_o and xfer_addr_o hold their values.
- R5: done_o is high for exactly one cycle, the cycle after the last transfer is taken. xfer_valid_o is low in that cycle, and busy_o is low in the cycle after it.
- R6: While done_o is high, final_base_o equals the captured base plus 4 times the number of set bits in the list. wb_o equals done_o AND the captured base-update bit.
- R7: A start with an all-zero list offers no transfer. It raises done_o in the next cycle, with final_base_o equal to the base.
- R8: A start strobe is ignored while busy_o is high, both during transfers and in the done cycle. The transfer stream, the done timing and the return to idle are unchanged.
- R9: The list, base, direction and base-update inputs are sampled only when a start is accepted. xfer_load_o shows the captured direction (1 = load, 0 = store) for the whole sequence.
- R10: Address and final-base arithmetic wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous-free active-low synchronous reset |
| start_i | input | 1 | Start strobe for a new request |
| reg_mask_i | input | 16 | Register list, bit n selects register n |
| base_i | input | 32 | Base byte address |
| load_i | input | 1 | Direction: 1 load, 0 store |
| wb_en_i | input | 1 | Request base update at the end |
| xfer_valid_o | output | 1 | A transfer is offered |
| xfer_idx_o | output | 4 | Register index of the offered transfer |
| xfer_addr_o | output | 32 | Word address of the offered transfer |
| xfer_load_o | output | 1 | Captured direction of the sequence |
| xfer_ready_i | input | 1 | Transfer taken this cycle when high with valid |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| final_base_o | output | 32 | Updated base, valid with done_o |
| wb_o | output | 1 | Base writeback strobe |
| busy_o | output | 1 | A sequence is in progress or finishing |

## Verification
Every result arrives one register stage after its cause. The first transfer shows up the cycle after the accepted start. Each new index and address shows up the cycle after a taken transfer. done_o, final_base_o and wb_o are due the cycle after the last taken transfer, or the cycle after a start with an empty list. busy_o falls one cycle after that. The bench drives the start and ready inputs at the falling edge and samples the outputs at the falling edge before driving the next value. Its expected index and address are therefore always the ones that the previous rising edge should have produced, and each stalled cycle is checked again against the same expected pair.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/blk_xfer_pick.sv
// Lowest-set-bit picker over the remaining register list.
module blk_xfer_pick #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  mask_i,
  output logic          any_o,
  output logic [N-1:0]  onehot_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0] below;

  assign below[0] = 1'b0;
  for (genvar g = 1; g < N; g++) begin : g_chain
    assign below[g] = below[g-1] | mask_i[g-1];
  end

  assign onehot_o = mask_i & ~below;
  assign any_o    = |mask_i;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot_o[i]) idx_o = idx_o | IW'(i);
    end
  end
endmodule

// File: rtl/blk_xfer_addr.sv
// Address walker and end-of-sequence base calculator.
module blk_xfer_addr #(
  parameter int N    = 16,
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en_i,
  input  logic [AW-1:0] base_i,
  input  logic [N-1:0]  mask_i,
  input  logic          step_en_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] final_o
);
  // Bytes covered by a register list: STEP per selected register.
  function automatic logic [AW-1:0] span_bytes(input logic [N-1:0] m);
    logic [AW-1:0] acc;
    acc = '0;
    for (int i = 0; i < N; i++) begin
      if (m[i]) acc = acc + AW'(STEP);
    end
    return acc;
  endfunction

  function automatic logic [AW-1:0] next_word(input logic [AW-1:0] a);
    return a + AW'(STEP);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_o  <= '0;
      final_o <= '0;
    end else if (load_en_i) begin
      addr_o  <= base_i;
      final_o <= base_i + span_bytes(mask_i);
    end else if (step_en_i) begin
      addr_o  <= next_word(addr_o);
    end
  end
endmodule

// File: rtl/blk_xfer_ctrl.sv
// Sequence state machine and working copy of the register list.
module blk_xfer_ctrl
  import blk_xfer_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [N-1:0] mask_i,
  input  logic         ready_i,
  input  logic [N-1:0] onehot_i,
  output logic [N-1:0] work_o,
  output xfer_state_e  state_o,
  output logic         start_acc_o,
  output logic         hs_o,
  output logic         last_o
);
  assign start_acc_o = start_i && (state_o == ST_IDLE);
  assign hs_o        = (state_o == ST_RUN) && ready_i;
  assign last_o      = ((work_o & ~onehot_i) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_o <= ST_IDLE;
      work_o  <= '0;
    end else begin
      unique case (state_o)
        ST_IDLE: begin
          if (start_acc_o) begin
            work_o  <= mask_i;
            state_o <= (mask_i == '0) ? ST_FIN : ST_RUN;
          end
        end
        ST_RUN: begin
          if (hs_o) begin
            work_o <= work_o & ~onehot_i;
            if (last_o) state_o <= ST_FIN;
          end
        end
        ST_FIN:  state_o <= ST_IDLE;
        default: state_o <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int NREGS      = 16,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [NREGS-1:0]  reg_mask_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              load_i,
  input  logic              wb_en_i,
  output logic              xfer_valid_o,
  output logic [IDX_W-1:0]  xfer_idx_o,
  output logic [ADDR_W-1:0] xfer_addr_o,
  output logic              xfer_load_o,
  input  logic              xfer_ready_i,
  output logic              done_o,
  output logic [ADDR_W-1:0] final_base_o,
  output logic              wb_o,
  output logic              busy_o
);
  // Named internal events, also watched by the bound checker.
  logic             start_acc_w;
  logic             hs_w;
  logic             last_w;
  logic             any_w;
  logic [NREGS-1:0] work_w;
  logic [NREGS-1:0] onehot_w;
  xfer_state_e      state_w;
  logic             load_q;
  logic             wb_q;

  blk_xfer_ctrl #(.N(NREGS)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mask_i      (reg_mask_i),
    .ready_i     (xfer_ready_i),
    .onehot_i    (onehot_w),
    .work_o      (work_w),
    .state_o     (state_w),
    .start_acc_o (start_acc_w),
    .hs_o        (hs_w),
    .last_o      (last_w)
  );

  blk_xfer_pick #(.N(NREGS), .IW(IDX_W)) u_pick (
    .mask_i   (work_w),
    .any_o    (any_w),
    .onehot_o (onehot_w),
    .idx_o    (xfer_idx_o)
  );

  blk_xfer_addr #(.N(NREGS), .AW(ADDR_W), .STEP(WORD_BYTES)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en_i (start_acc_w),
    .base_i    (base_i),
    .mask_i    (reg_mask_i),
    .step_en_i (hs_w),
    .addr_o    (xfer_addr_o),
    .final_o   (final_base_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q <= 1'b0;
      wb_q   <= 1'b0;
    end else if (start_acc_w) begin
      load_q <= load_i;
      wb_q   <= wb_en_i;
    end
  end

  assign xfer_valid_o = (state_w == ST_RUN) && any_w;
  assign xfer_load_o  = load_q;
  assign done_o       = (state_w == ST_FIN);
  assign wb_o         = done_o && wb_q;
  assign busy_o       = (state_w != ST_IDLE);
endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
  parameter int N    = 16,
  parameter int AW   = 32,
  parameter int IW   = 4,
  parameter int STEP = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [N-1:0]  reg_mask_i,
  input logic [AW-1:0] base_i,
  input logic          busy_o,
  input logic          xfer_valid_o,
  input logic          xfer_ready_i,
  input logic [IW-1:0] xfer_idx_o,
  input logic [AW-1:0] xfer_addr_o,
  input logic          done_o,
  input logic          wb_o,
  input logic          hs_w,
  input logic          last_w
);
  p_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && reg_mask_i != '0) |=>
      (xfer_valid_o && xfer_addr_o == $past(base_i)));

  p_idx_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_w && !last_w) |=> (xfer_valid_o && xfer_idx_o > $past(xfer_idx_o)));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_w && !last_w) |=> (xfer_addr_o == $past(xfer_addr_o) + AW'(STEP)));

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && !xfer_ready_i) |=>
      (xfer_valid_o && $stable(xfer_idx_o) && $stable(xfer_addr_o)));

  p_last_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_w && last_w) |=> (done_o && !xfer_valid_o));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  p_wb_in_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_o |-> done_o);

  p_empty_list_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && reg_mask_i == '0) |=> (done_o && !xfer_valid_o));

  p_valid_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid_o |-> (busy_o && !done_o));
endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(
  .N(NREGS), .AW(ADDR_W), .IW(IDX_W), .STEP(WORD_BYTES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .reg_mask_i   (reg_mask_i),
  .base_i       (base_i),
  .busy_o       (busy_o),
  .xfer_valid_o (xfer_valid_o),
  .xfer_ready_i (xfer_ready_i),
  .xfer_idx_o   (xfer_idx_o),
  .xfer_addr_o  (xfer_addr_o),
  .done_o       (done_o),
  .wb_o         (wb_o),
  .hs_w         (hs_w),
  .last_w       (last_w)
);

// File: tb/blk_xfer_seq_test.sv
module blk_xfer_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] mask_i = '0;
  logic [31:0] base_i = '0;
  logic        load_i = 1'b0;
  logic        wb_i = 1'b0;
  logic        ready_i = 1'b0;
  logic        valid_o, load_o, done_o, wb_o, busy_o;
  logic [3:0]  idx_o;
  logic [31:0] addr_o, final_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit ended   = 1'b0;

  always #5 clk = ~clk;

  blk_xfer_seq uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .reg_mask_i   (mask_i),
    .base_i       (base_i),
    .load_i       (load_i),
    .wb_en_i      (wb_i),
    .xfer_valid_o (valid_o),
    .xfer_idx_o   (idx_o),
    .xfer_addr_o  (addr_o),
    .xfer_load_o  (load_o),
    .xfer_ready_i (ready_i),
    .done_o       (done_o),
    .final_base_o (final_o),
    .wb_o         (wb_o),
    .busy_o       (busy_o)
  );

  // Vector: {mask[16], base[32], load, wb, ready pattern[8], poke}
  localparam logic [58:0] VEC [6] = '{
    {16'h8001, 32'h0000_1000, 1'b1, 1'b1, 8'hFF, 1'b0},
    {16'hFFFF, 32'h2000_0000, 1'b0, 1'b1, 8'hA5, 1'b0},
    {16'h0000, 32'h0000_0300, 1'b1, 1'b1, 8'hFF, 1'b0},
    {16'h000F, 32'hFFFF_FFF8, 1'b1, 1'b0, 8'h6D, 1'b0},
    {16'h0011, 32'h0000_0100, 1'b0, 1'b1, 8'hFF, 1'b1},
    {16'h4210, 32'h4444_0000, 1'b1, 1'b1, 8'h01, 1'b1}
  };

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      summary();
    end
  end

  task automatic run_seq(input logic [58:0] v);
    logic [15:0] m;
    logic [31:0] b, exp_addr;
    logic        ld, w, poke;
    logic [7:0]  pat;
    int          c, k;
    bit          taken, first;
    m = v[58:43]; b = v[42:11]; ld = v[10]; w = v[9]; pat = v[8:1]; poke = v[0];
    @(negedge clk);
    start_i = 1'b1; mask_i = m; base_i = b; load_i = ld; wb_i = w;
    @(negedge clk);
    start_i = 1'b0; ready_i = 1'b0;
    c = 0; k = 0; first = 1'b1;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        exp_addr = b + 32'(4 * k);
        taken = 1'b0;
        while (!taken) begin
          chk(valid_o === 1'b1, "R2/R4 valid", 32'(valid_o), 32'd1);
          chk(idx_o === 4'(i), "R3 index order", 32'(idx_o), 32'(i));
          chk(addr_o === exp_addr, "R3/R10 address", addr_o, exp_addr);
          chk(load_o === ld, "R9 direction", 32'(load_o), 32'(ld));
          if (poke && first) begin
            // R8/R9: start and new inputs while busy must be ignored
            start_i = 1'b1; mask_i = ~m; base_i = ~b; load_i = ~ld; wb_i = ~w;
          end
          first = 1'b0;
          ready_i = pat[c % 8];
          taken = ready_i;
          c++;
          @(negedge clk);
          start_i = 1'b0; ready_i = 1'b0;
        end
        k++;
      end
    end
    chk(done_o === 1'b1, (m == 0) ? "R7 empty done" : "R5 done", 32'(done_o), 32'd1);
    chk(valid_o === 1'b0, (m == 0) ? "R7 no transfer" : "R5 valid low", 32'(valid_o), 32'd0);
    chk(final_o === b + 32'(4 * k), "R6/R10 final base", final_o, b + 32'(4 * k));
    chk(wb_o === w, "R6 writeback", 32'(wb_o), 32'(w));
    if (poke) begin
      start_i = 1'b1; mask_i = 16'h0003; base_i = 32'h55;
    end
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o === 1'b0, "R5 single pulse", 32'(done_o), 32'd0);
    chk(busy_o === 1'b0, "R5/R8 idle after done", 32'(busy_o), 32'd0);
    chk(valid_o === 1'b0, "R8 no restart", 32'(valid_o), 32'd0);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(valid_o === 1'b0, "R1 valid in reset", 32'(valid_o), 32'd0);
    chk(done_o === 1'b0, "R1 done in reset", 32'(done_o), 32'd0);
    chk(busy_o === 1'b0, "R1 busy in reset", 32'(busy_o), 32'd0);
    chk(wb_o === 1'b0, "R1 wb in reset", 32'(wb_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o === 1'b0, "R1 idle after reset", 32'(busy_o), 32'd0);

    for (int n = 0; n < 6; n++) run_seq(VEC[n]);

    // R1: reset in mid sequence abandons it
    @(negedge clk);
    start_i = 1'b1; mask_i = 16'h00FF; base_i = 32'h800; ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    chk(valid_o === 1'b1, "R2 started", 32'(valid_o), 32'd1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(valid_o === 1'b0, "R1 mid reset valid", 32'(valid_o), 32'd0);
    chk(busy_o === 1'b0, "R1 mid reset busy", 32'(busy_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done_o === 1'b0, "R1 no done after reset", 32'(done_o), 32'd0);

    // Back-to-back: single register right after reset
    run_seq({16'h0400, 32'h0000_0040, 1'b0, 1'b0, 8'hFF, 1'b0});
    summary();
  end
endmodule